// File: doc/BRIEF.md
# Serial Control Register Loader

This block is a three-wire serial slave that fills a bank of 8-bit control registers for a video line-timing engine. A host frames each write with an active-low select strobe. While the strobe is low it shifts sixteen bits on a serial clock: an 8-bit register address followed by an 8-bit value. When the strobe returns high, the value is committed to the addressed register. The register contents are presented as parallel outputs for the timing engine to use.

The address map is sparse. It holds four start-position registers and two 11-bit line lengths, each split into a low byte and a 3-bit high part at separate addresses. It also holds an eight-entry line-count table, an eight-entry mode table, four blanking edges and an I/O data byte with a PAL 4:3 select bit. The three serial lines are oversampled by a fast system clock. Each line passes through a two-flop synchronizer, and edges are detected in the system clock domain. The serial clock must therefore stay well below the system clock rate; a half-period of several system cycles is expected.

Top module: `scan_ctl_regs`

## Requirements
- R1: While reset is asserted and right after it, every register reads zero, except the write line length, which reads 11'h38C.
- R2: A falling edge on the select strobe starts a frame. Bits are taken on rising serial clock edges, most significant bit first. The first eight bits are the address and the next eight are the value. The write takes effect on the rising edge of the strobe, at most four system cycles after that edge is synchronized.
- R3: Addresses 00h, 10h, 20h and 30h load the horizontal write start, vertical write start, horizontal read start and vertical read start bytes.
- R4: The read line length takes bits 7..0 from address 40h and bits 10..8 from bits 2..0 of the value written to 50h. The write line length uses 41h and 51h in the same way. Value bits 7..3 sent to 50h or 51h are dropped.
- R5: Addresses 60h+k and 70h+k, for k from 0 to 7, load entry k of the line-count table and of the mode table. Entry k appears on bits 8k+7..8k of the matching flat output.
- R6: Addresses A0h, B0h, C0h and D0h load the top, bottom, left and right blanking bytes.
- R7: Address 80h loads the I/O data byte. The PAL select output equals bit 3 of that byte (1 means PAL 4:3).
- R8: A frame that ends with other than exactly sixteen counted clock edges (for example 15 or 17) changes no register.
- R9: A complete frame to an address outside the map (for example 08h, 42h, 68h or FFh) changes no register.
- R10: Serial clock edges while the strobe is high change no register.
- R11: A serial clock rise that lands in the same system cycle as the strobe rise ends the frame and is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial bit clock, bits taken on its rising edge |
| serStrobe | input | 1 | Active-low frame select |
| serData | input | 1 | Serial address and data bits |
| hWrStart | output | 8 | Horizontal write start |
| vWrStart | output | 8 | Vertical write start |
| hRdStart | output | 8 | Horizontal read start |
| vRdStart | output | 8 | Vertical read start |
| rdLineLen | output | 11 | Read line length |
| wrLineLen | output | 11 | Write line length |
| lineCountFlat | output | 64 | Line-count table, entry k at bits 8k+7..8k |
| modeFlat | output | 64 | Mode table, entry k at bits 8k+7..8k |
| blankTop | output | 8 | Top blanking edge |
| blankBottom | output | 8 | Bottom blanking edge |
| blankLeft | output | 8 | Left blanking edge |
| blankRight | output | 8 | Right blanking edge |
| ioData | output | 8 | I/O data byte |
| palMode | output | 1 | PAL 4:3 select, bit 3 of the I/O data byte |

## Verification
The two events that can share a system cycle are a serial clock rise and the strobe rise that closes the frame. The bench provokes this by moving both lines in the same time step, so that both cross the synchronizers together. Two cases are judged at the register outputs. If sixteen edges have already been counted, the write must still land. If only fifteen have been counted, the coinciding edge must not become the sixteenth bit, and the target register must keep its old value.

// File: rtl/scanctl_pkg.sv
`timescale 1ns/1ps
package scanctl_pkg;

  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 8;
  localparam int LEN_HI_W   = 3;
  localparam int TABLE_N    = 8;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int PAL_BIT    = 3;

  localparam logic [ADDR_W-1:0] A_HWR_START = 8'h00;
  localparam logic [ADDR_W-1:0] A_VWR_START = 8'h10;
  localparam logic [ADDR_W-1:0] A_HRD_START = 8'h20;
  localparam logic [ADDR_W-1:0] A_VRD_START = 8'h30;
  localparam logic [ADDR_W-1:0] A_RDLEN_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] A_WRLEN_LO  = 8'h41;
  localparam logic [ADDR_W-1:0] A_RDLEN_HI  = 8'h50;
  localparam logic [ADDR_W-1:0] A_WRLEN_HI  = 8'h51;
  localparam logic [ADDR_W-1:0] A_LCNT_BASE = 8'h60;
  localparam logic [ADDR_W-1:0] A_MODE_BASE = 8'h70;
  localparam logic [ADDR_W-1:0] A_IO_DATA   = 8'h80;
  localparam logic [ADDR_W-1:0] A_BLK_TOP   = 8'hA0;
  localparam logic [ADDR_W-1:0] A_BLK_BOT   = 8'hB0;
  localparam logic [ADDR_W-1:0] A_BLK_LEFT  = 8'hC0;
  localparam logic [ADDR_W-1:0] A_BLK_RIGHT = 8'hD0;

  localparam logic [DATA_W+LEN_HI_W-1:0] WR_LEN_RESET = 11'h38C;

  // Strobes from the serial sequencer to the register bank
  typedef struct packed {
    logic start;   // frame opened
    logic shift;   // take bitVal into the shift register
    logic bitVal;  // synchronized serial data bit
    logic commit;  // frame closed with the full bit count
    logic abort;   // frame closed with a wrong bit count
  } ctlStrb_t;

endpackage

// File: rtl/scan_ctl_seq.sv
`timescale 1ns/1ps
module scan_ctl_seq
  import scanctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NBITS       = FRAME_BITS
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serStrobe,
  input  logic     serData,
  output ctlStrb_t strb
);

  localparam int CNT_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(NBITS + 1);

  logic [SYNC_STAGES-1:0] clkSync, strbSync, datSync;
  logic clkPrev, strbPrev;
  logic inFrame;
  logic [CNT_W-1:0] bitCnt;

  // Strobe line idles high, so its synchronizer resets high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= '0;
      strbSync <= '1;
      datSync  <= '0;
      clkPrev  <= 1'b0;
      strbPrev <= 1'b1;
    end else begin
      clkSync  <= {clkSync[SYNC_STAGES-2:0], serClk};
      strbSync <= {strbSync[SYNC_STAGES-2:0], serStrobe};
      datSync  <= {datSync[SYNC_STAGES-2:0], serData};
      clkPrev  <= clkSync[SYNC_STAGES-1];
      strbPrev <= strbSync[SYNC_STAGES-1];
    end
  end

  logic clkRise, strbRise, strbFall;
  assign clkRise  = clkSync[SYNC_STAGES-1] & ~clkPrev;
  assign strbRise = strbSync[SYNC_STAGES-1] & ~strbPrev;
  assign strbFall = ~strbSync[SYNC_STAGES-1] & strbPrev;

  // Frame end wins over a coinciding serial clock rise
  always_comb begin
    strb.start  = strbFall;
    strb.shift  = inFrame & clkRise & ~strbRise;
    strb.bitVal = datSync[SYNC_STAGES-1];
    strb.commit = inFrame & strbRise & (bitCnt == CNT_FULL);
    strb.abort  = inFrame & strbRise & (bitCnt != CNT_FULL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
    end else if (strbFall) begin
      inFrame <= 1'b1;
      bitCnt  <= '0;
    end else if (strbRise) begin
      inFrame <= 1'b0;
    end else if (strb.shift && bitCnt != CNT_SAT) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

endmodule

// File: rtl/scan_ctl_bank.sv
`timescale 1ns/1ps
module scan_ctl_bank
  import scanctl_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int AW     = ADDR_W,
  parameter int HW     = LEN_HI_W,
  parameter int ENTRIES = TABLE_N
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrb_t              strb,
  output logic [DW-1:0]         hWrStart,
  output logic [DW-1:0]         vWrStart,
  output logic [DW-1:0]         hRdStart,
  output logic [DW-1:0]         vRdStart,
  output logic [DW+HW-1:0]      rdLineLen,
  output logic [DW+HW-1:0]      wrLineLen,
  output logic [ENTRIES*DW-1:0] lineCountFlat,
  output logic [ENTRIES*DW-1:0] modeFlat,
  output logic [DW-1:0]         blankTop,
  output logic [DW-1:0]         blankBottom,
  output logic [DW-1:0]         blankLeft,
  output logic [DW-1:0]         blankRight,
  output logic [DW-1:0]         ioData,
  output logic                  palMode
);

  localparam int SR_W = AW + DW;

  logic [SR_W-1:0] shiftReg;
  logic [AW-1:0]   wAddr;
  logic [DW-1:0]   wData;

  always_ff @(posedge clk) begin
    if (!rstN)                      shiftReg <= '0;
    else if (strb.start || strb.abort) shiftReg <= '0;
    else if (strb.shift)            shiftReg <= {shiftReg[SR_W-2:0], strb.bitVal};
  end

  assign wAddr = shiftReg[SR_W-1 -: AW];
  assign wData = shiftReg[DW-1:0];

  logic [DW-1:0] rdLenLo, wrLenLo;
  logic [HW-1:0] rdLenHi, wrLenHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hWrStart    <= '0;
      vWrStart    <= '0;
      hRdStart    <= '0;
      vRdStart    <= '0;
      rdLenLo     <= '0;
      rdLenHi     <= '0;
      wrLenLo     <= WR_LEN_RESET[DW-1:0];
      wrLenHi     <= WR_LEN_RESET[DW+HW-1:DW];
      blankTop    <= '0;
      blankBottom <= '0;
      blankLeft   <= '0;
      blankRight  <= '0;
      ioData      <= '0;
    end else if (strb.commit) begin
      unique case (wAddr)
        A_HWR_START: hWrStart    <= wData;
        A_VWR_START: vWrStart    <= wData;
        A_HRD_START: hRdStart    <= wData;
        A_VRD_START: vRdStart    <= wData;
        A_RDLEN_LO:  rdLenLo     <= wData;
        A_RDLEN_HI:  rdLenHi     <= wData[HW-1:0];
        A_WRLEN_LO:  wrLenLo     <= wData;
        A_WRLEN_HI:  wrLenHi     <= wData[HW-1:0];
        A_BLK_TOP:   blankTop    <= wData;
        A_BLK_BOT:   blankBottom <= wData;
        A_BLK_LEFT:  blankLeft   <= wData;
        A_BLK_RIGHT: blankRight  <= wData;
        A_IO_DATA:   ioData      <= wData;
        default: ;
      endcase
    end
  end

  assign rdLineLen = {rdLenHi, rdLenLo};
  assign wrLineLen = {wrLenHi, wrLenLo};
  assign palMode   = ioData[PAL_BIT];

  // One line-count and one mode byte per table slot
  for (genvar k = 0; k < ENTRIES; k++) begin : g_table
    localparam logic [AW-1:0] LCNT_ADR = A_LCNT_BASE + AW'(k);
    localparam logic [AW-1:0] MODE_ADR = A_MODE_BASE + AW'(k);
    logic [DW-1:0] lcntEntry, modeEntry;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lcntEntry <= '0;
        modeEntry <= '0;
      end else if (strb.commit) begin
        if (wAddr == LCNT_ADR) lcntEntry <= wData;
        if (wAddr == MODE_ADR) modeEntry <= wData;
      end
    end

    assign lineCountFlat[k*DW +: DW] = lcntEntry;
    assign modeFlat[k*DW +: DW]      = modeEntry;
  end

endmodule

// File: rtl/scan_ctl_regs.sv
`timescale 1ns/1ps
module scan_ctl_regs
  import scanctl_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        serClk,
  input  logic                        serStrobe,
  input  logic                        serData,
  output logic [DATA_W-1:0]           hWrStart,
  output logic [DATA_W-1:0]           vWrStart,
  output logic [DATA_W-1:0]           hRdStart,
  output logic [DATA_W-1:0]           vRdStart,
  output logic [DATA_W+LEN_HI_W-1:0]  rdLineLen,
  output logic [DATA_W+LEN_HI_W-1:0]  wrLineLen,
  output logic [TABLE_N*DATA_W-1:0]   lineCountFlat,
  output logic [TABLE_N*DATA_W-1:0]   modeFlat,
  output logic [DATA_W-1:0]           blankTop,
  output logic [DATA_W-1:0]           blankBottom,
  output logic [DATA_W-1:0]           blankLeft,
  output logic [DATA_W-1:0]           blankRight,
  output logic [DATA_W-1:0]           ioData,
  output logic                        palMode
);

  ctlStrb_t strb;

  scan_ctl_seq #(.SYNC_STAGES(2), .NBITS(FRAME_BITS)) i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serStrobe (serStrobe),
    .serData   (serData),
    .strb      (strb)
  );

  scan_ctl_bank #(.DW(DATA_W), .AW(ADDR_W), .HW(LEN_HI_W), .ENTRIES(TABLE_N)) i_bank (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .hWrStart      (hWrStart),
    .vWrStart      (vWrStart),
    .hRdStart      (hRdStart),
    .vRdStart      (vRdStart),
    .rdLineLen     (rdLineLen),
    .wrLineLen     (wrLineLen),
    .lineCountFlat (lineCountFlat),
    .modeFlat      (modeFlat),
    .blankTop      (blankTop),
    .blankBottom   (blankBottom),
    .blankLeft     (blankLeft),
    .blankRight    (blankRight),
    .ioData        (ioData),
    .palMode       (palMode)
  );

endmodule

// File: rtl/scan_ctl_regs_chk.sv
`timescale 1ns/1ps
module scan_ctl_regs_chk
  import scanctl_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input ctlStrb_t                   strb,
  input logic [DATA_W-1:0]          hWrStart,
  input logic [DATA_W-1:0]          vWrStart,
  input logic [DATA_W-1:0]          hRdStart,
  input logic [DATA_W-1:0]          vRdStart,
  input logic [DATA_W+LEN_HI_W-1:0] rdLineLen,
  input logic [DATA_W+LEN_HI_W-1:0] wrLineLen,
  input logic [TABLE_N*DATA_W-1:0]  lineCountFlat,
  input logic [TABLE_N*DATA_W-1:0]  modeFlat,
  input logic [DATA_W-1:0]          blankTop,
  input logic [DATA_W-1:0]          blankBottom,
  input logic [DATA_W-1:0]          blankLeft,
  input logic [DATA_W-1:0]          blankRight,
  input logic [DATA_W-1:0]          ioData
);

  // R2
  starts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> ($stable(hWrStart) && $stable(vWrStart) &&
                             $stable(hRdStart) && $stable(vRdStart)));

  // R4
  line_len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> ($stable(rdLineLen) && $stable(wrLineLen)));

  // R5
  tables_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> ($stable(lineCountFlat) && $stable(modeFlat)));

  // R6
  blank_io_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> ($stable(blankTop) && $stable(blankBottom) &&
                             $stable(blankLeft) && $stable(blankRight) && $stable(ioData)));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shift, strb.commit, strb.abort}));

  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!$stable(hWrStart), !$stable(vWrStart), !$stable(hRdStart),
              !$stable(vRdStart), !$stable(blankTop), !$stable(blankBottom),
              !$stable(blankLeft), !$stable(blankRight), !$stable(ioData)}));

endmodule

bind scan_ctl_regs scan_ctl_regs_chk i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .strb          (strb),
  .hWrStart      (hWrStart),
  .vWrStart      (vWrStart),
  .hRdStart      (hRdStart),
  .vRdStart      (vRdStart),
  .rdLineLen     (rdLineLen),
  .wrLineLen     (wrLineLen),
  .lineCountFlat (lineCountFlat),
  .modeFlat      (modeFlat),
  .blankTop      (blankTop),
  .blankBottom   (blankBottom),
  .blankLeft     (blankLeft),
  .blankRight    (blankRight),
  .ioData        (ioData)
);

// File: tb/test_scan_ctl_regs.sv
`timescale 1ns/1ps
module test_scan_ctl_regs;

  localparam int HALF   = 40;   // serial half period, 8 system clocks
  localparam int SETTLE = 100;  // wait after strobe rise

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serStrobe = 1'b1;
  logic serData = 1'b0;

  logic [7:0]  hWrStart, vWrStart, hRdStart, vRdStart;
  logic [10:0] rdLineLen, wrLineLen;
  logic [63:0] lineCountFlat, modeFlat;
  logic [7:0]  blankTop, blankBottom, blankLeft, blankRight, ioData;
  logic        palMode;

  int nCompared = 0;
  int nMismatch = 0;

  always #2.5 clk = ~clk;

  scan_ctl_regs i_scan_ctl_regs (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serStrobe(serStrobe), .serData(serData),
    .hWrStart(hWrStart), .vWrStart(vWrStart), .hRdStart(hRdStart), .vRdStart(vRdStart),
    .rdLineLen(rdLineLen), .wrLineLen(wrLineLen),
    .lineCountFlat(lineCountFlat), .modeFlat(modeFlat),
    .blankTop(blankTop), .blankBottom(blankBottom), .blankLeft(blankLeft),
    .blankRight(blankRight), .ioData(ioData), .palMode(palMode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Send nEdges serial clock rises, MSB first; optionally raise the strobe
  // together with the last rise
  task automatic sendFrame(input logic [15:0] word, input int nEdges, input bit lastTogether);
    serStrobe = 1'b0;
    #HALF;
    for (int i = 0; i < nEdges; i++) begin
      serData = (i < 16) ? word[15-i] : 1'b0;
      #HALF;
      if (lastTogether && i == nEdges - 1) begin
        serClk = 1'b1; serStrobe = 1'b1;
        #HALF; serClk = 1'b0;
      end else begin
        serClk = 1'b1;
        #HALF; serClk = 1'b0;
      end
    end
    if (!lastTogether) begin
      #HALF; serStrobe = 1'b1;
    end
    #SETTLE;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    sendFrame({a, d}, 16, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 hWrStart", hWrStart, 0);
    check("R1 vRdStart", vRdStart, 0);
    check("R1 rdLineLen", rdLineLen, 0);
    check("R1 wrLineLen", wrLineLen, 11'h38C);
    check("R1 tables", lineCountFlat | modeFlat, 0);
    check("R1 blank+io", {blankTop, blankBottom, blankLeft, blankRight, ioData, 7'd0, palMode}, 0);
  endtask

  task automatic t_starts();
    writeReg(8'h00, 8'h11);
    writeReg(8'h10, 8'h22);
    writeReg(8'h20, 8'h33);
    writeReg(8'h30, 8'h44);
    check("R2 R3 starts", {hWrStart, vWrStart, hRdStart, vRdStart}, 32'h11223344);
  endtask

  task automatic t_lineLen();
    writeReg(8'h40, 8'hAB);
    writeReg(8'h50, 8'hFF);
    check("R4 rdLineLen", rdLineLen, 11'h7AB);
    writeReg(8'h41, 8'h12);
    writeReg(8'h51, 8'hF5);
    check("R4 wrLineLen", wrLineLen, 11'h512);
  endtask

  task automatic t_tables();
    logic [63:0] expL, expM;
    expL = '0; expM = '0;
    for (int k = 0; k < 8; k++) begin
      writeReg(8'h60 + 8'(k), 8'h10 + 8'(k));
      writeReg(8'h70 + 8'(k), 8'hC0 - 8'(k));
      expL[k*8 +: 8] = 8'h10 + 8'(k);
      expM[k*8 +: 8] = 8'hC0 - 8'(k);
    end
    check("R5 lineCountFlat", lineCountFlat, expL);
    check("R5 modeFlat", modeFlat, expM);
  endtask

  task automatic t_blank();
    writeReg(8'hA0, 8'h05);
    writeReg(8'hB0, 8'hE6);
    writeReg(8'hC0, 8'h17);
    writeReg(8'hD0, 8'hF8);
    check("R6 blanking", {blankTop, blankBottom, blankLeft, blankRight}, 32'h05E617F8);
  endtask

  task automatic t_io();
    writeReg(8'h80, 8'h08);
    check("R7 io pal on", {ioData, 7'd0, palMode}, 16'h0801);
    writeReg(8'h80, 8'hF7);
    check("R7 io pal off", {ioData, 7'd0, palMode}, 16'hF700);
  endtask

  task automatic t_badCount();
    sendFrame(16'h0055, 15, 1'b0);
    check("R8 15 edges", hWrStart, 8'h11);
    sendFrame(16'h0066, 17, 1'b0);
    check("R8 17 edges", hWrStart, 8'h11);
  endtask

  task automatic t_unmapped(input logic [63:0] expL, input logic [63:0] expM);
    writeReg(8'h08, 8'h99);
    writeReg(8'h42, 8'h9A);
    writeReg(8'h68, 8'h9B);
    writeReg(8'hFF, 8'h9C);
    check("R9 starts", {hWrStart, vWrStart, hRdStart, vRdStart}, 32'h11223344);
    check("R9 lengths", {rdLineLen, wrLineLen}, {11'h7AB, 11'h512});
    check("R9 tables", lineCountFlat ^ modeFlat, expL ^ expM);
    check("R9 blank+io", {blankTop, blankBottom, blankLeft, blankRight, ioData}, 40'h05E617F8F7);
  endtask

  task automatic t_idleClk();
    serData = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #HALF; serClk = 1'b1;
      #HALF; serClk = 1'b0;
    end
    #SETTLE;
    check("R10 idle clocks", {hWrStart, vWrStart, hRdStart, vRdStart, ioData}, 40'h11223344F7);
  endtask

  task automatic t_coincide();
    writeReg(8'h30, 8'h5A);
    sendFrame(16'h30A5, 15, 1'b0);
    check("R11 base", vRdStart, 8'h5A);
    sendFrame(16'h30C3, 17, 1'b1);
    check("R11 17th edge with strobe", vRdStart, 8'hC3);
    sendFrame(16'h303C, 16, 1'b1);
    check("R11 16th edge with strobe", vRdStart, 8'hC3);
  endtask

  initial begin
    #1_000_000;
    nMismatch++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    logic [63:0] keepL, keepM;
    #23;
    t_reset();
    rstN = 1'b1;
    #20;
    t_reset();
    t_starts();
    t_lineLen();
    t_tables();
    t_blank();
    t_io();
    t_badCount();
    keepL = lineCountFlat;
    keepM = modeFlat;
    t_unmapped(keepL, keepM);
    t_idleClk();
    t_coincide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule